// File: doc/BRIEF.md
# Multiplexed External Memory Bus Sequencer

This block turns a simple internal access request into the pin-level sequence of an 8-bit external memory bus. A request names one of three operations (code fetch, data read, data write), carries a 16-bit address, a flag that says whether a data access uses a full 16-bit pointer or an 8-bit register address, and a write byte. The block runs every access in one machine cycle of 12 oscillator clocks. A machine cycle holds 6 states of 2 clocks each. Phase 0 is the first clock of state 1 and phase 11 is the last clock of state 6.

The low address byte and the data byte share one 8-bit port. An address latch strobe marks the clocks in which the low address is valid, so an outside latch can capture it. A second 8-bit port carries either the high address byte or the value of a port register that the core supplies. Separate active-low strobes serve code fetches, data reads and data writes. A raw reset pin is filtered: it takes effect only after it has been high for two whole machine cycles.

Top module: `xbus_sequencer`

## Requirements
- R1: In an access cycle the shared port is driven (`ad_oe`=1) with `req_addr[7:0]` in phases 0 to 5. A write keeps the port driven in phases 6 to 11 with the write byte. Fetches and reads release the port (`ad_oe`=0) in phases 6 to 11.
- R2: `ale` is high in phase 1 of every machine cycle. It is also high in phase 7, except in a data read or data write cycle.
- R3: In a cycle with no access, `ale` pulses once every 6 clocks (phases 1 and 7), all three strobes stay high, `ad_oe` is 0 and `done` is 0.
- R4: For a code fetch (kind 0), whatever the pointer flag, and for a data access with `req_wide`=1, `a_hi` equals `req_addr[15:8]` for the whole access cycle.
- R5: In a data access with `req_wide`=0, and in every cycle with no access, `a_hi` equals `p2_reg`.
- R6: A data read (kind 1) drives `rd_n` low in phases 6 to 11. `code_rd_n` and `wr_n` stay high.
- R7: A data write (kind 2) drives `wr_n` low in phases 6 to 10. The write byte is still on the port in phase 11, after `wr_n` has risen. `code_rd_n` and `rd_n` stay high.
- R8: For fetches and reads, `rdata` takes `ad_in` at the clock edge that ends phase 11, which is the edge at which the read strobe rises. A write leaves `rdata` unchanged.
- R9: A code fetch (kind 0) drives `code_rd_n` low in phases 6 to 11. `rd_n` and `wr_n` stay high.
- R10: A request is accepted only at the edge that ends phase 11 of a cycle with no access in progress. The access then runs in the next machine cycle. Request fields that change after acceptance have no effect. `done` is high for exactly phase 11 of the access cycle. A request still held at that edge is not taken again, so a cycle with no access follows.
- R11: `reset_in` resets the block only once it has been high at 24 consecutive clock edges; a shorter pulse has no effect. In reset, `ale` is 0, all strobes are high, `ad_oe` and `done` are 0, and `rdata` is 0. After release the cycle restarts: phase 0 is the first clock and `ale` is high on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| reset_in | input | 1 | Raw active-high reset pin, filtered |
| req_valid | input | 1 | Access request, held until `done` |
| req_kind | input | 2 | 0 code fetch, 1 data read, 2 data write |
| req_wide | input | 1 | Data access uses a 16-bit pointer |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| p2_reg | input | 8 | High port register value |
| ad_in | input | 8 | Shared port input |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| a_hi | output | 8 | High port: address high byte or `p2_reg` |
| ale | output | 1 | Address latch strobe |
| code_rd_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| done | output | 1 | Access complete, one clock |
| rdata | output | 8 | Byte captured by the last fetch or read |

## Verification
The assertions assume that `req_kind` never takes the reserved value 3. They also assume that a requester keeps `req_valid` and its fields steady until the acceptance edge. The stimulus uses only the three defined kinds. It changes request fields only at falling clock edges: it loads them in phase 5 of a cycle with no access and scrambles them in phase 0 of the access. Reset pulses are applied and removed at falling edges, so their length counted in edges is exact.

// File: rtl/xbus_pkg.sv
// Shared widths, access kinds and the latched request record used by the
// external bus sequencer. Assumes an 8-bit data path and a 16-bit address.
package xbus_pkg;
    localparam int XB_ADDR_W = 16;
    localparam int XB_DATA_W = 8;

    typedef enum logic [1:0] {
        XK_FETCH  = 2'd0,
        XK_DREAD  = 2'd1,
        XK_DWRITE = 2'd2,
        XK_RSVD   = 2'd3
    } xbus_kind_e;

    typedef struct packed {
        xbus_kind_e                 kind;
        logic                       wide;
        logic [XB_ADDR_W-1:0]       addr;
        logic [XB_DATA_W-1:0]       wdata;
    } xbus_req_t;
endpackage

// File: rtl/xbus_rst_filter.sv
// Qualifies a raw active-high reset pin. The internal active-low reset goes
// active only after the pin has been high at HOLD_CLKS consecutive edges,
// and it stays active while the pin remains high. Assumes the pin is already
// synchronous to clk.
module xbus_rst_filter #(
    parameter int HOLD_CLKS = 24
) (
    input  logic clk,
    input  logic raw_rst,
    output logic core_rst_n
);
    localparam int CW = $clog2(HOLD_CLKS + 1);
    localparam logic [CW-1:0] SAT  = CW'(HOLD_CLKS);
    localparam logic [CW-1:0] TRIG = CW'(HOLD_CLKS - 1);

    logic [CW-1:0] high_cnt;

    // Count consecutive high edges of the pin, saturating at the hold length.
    always_ff @(posedge clk) begin
        if (!raw_rst)
            high_cnt <= '0;
        else if (high_cnt != SAT)
            high_cnt <= high_cnt + 1'b1;
    end

    // Register the qualified reset once the hold length is reached.
    always_ff @(posedge clk) begin
        core_rst_n <= !(raw_rst && (high_cnt >= TRIG));
    end
endmodule

// File: rtl/xbus_phase_gen.sv
// Free-running machine cycle phase counter. Counts 0..PHASES-1 and flags the
// last clock of each cycle. Synchronous active-low reset returns it to 0.
module xbus_phase_gen #(
    parameter int PHASES = 12,
    localparam int PH_W = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            cycle_end
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    assign cycle_end = (phase == LAST);

    // Advance the phase every clock and wrap at the end of the machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (cycle_end)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end
endmodule

// File: rtl/xbus_access_ctl.sv
// Request acceptance and completion. A request is latched at the end of a
// machine cycle with no access in progress. The access runs for the whole
// next cycle, and done marks its last clock. Fetch and read data are
// captured from the shared port on that final edge. Assumes the requester
// holds its request until done.
module xbus_access_ctl
    import xbus_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cycle_end,
    input  logic                 req_valid,
    input  xbus_req_t            req_in,
    input  logic [XB_DATA_W-1:0] ad_in,
    output logic                 busy,
    output xbus_req_t            cur,
    output logic                 done,
    output logic [XB_DATA_W-1:0] rdata
);
    assign done = busy && cycle_end;

    // Latch a request at a free cycle boundary, retire it one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cur   <= '0;
            rdata <= '0;
        end else if (cycle_end) begin
            if (busy) begin
                busy <= 1'b0;
                if (cur.kind != XK_DWRITE)
                    rdata <= ad_in;
            end else if (req_valid) begin
                busy <= 1'b1;
                cur  <= req_in;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10
endmodule

// File: rtl/xbus_pin_mux.sv
// Decodes the phase and the latched access into the pin-level signals:
// latch strobe, the three active-low strobes, the shared port drive and the
// high port value. All outputs are decoded from registered state, so they
// change only after a clock edge. Reset forces every strobe inactive.
module xbus_pin_mux
    import xbus_pkg::*;
#(
    parameter int CLKS_PER_STATE = 2,
    parameter int STATES = 6,
    localparam int PHASES = CLKS_PER_STATE * STATES,
    localparam int PH_W = $clog2(PHASES),
    localparam int HI_W = XB_ADDR_W - XB_DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PH_W-1:0]      phase,
    input  logic                 busy,
    input  xbus_req_t            cur,
    input  logic [HI_W-1:0]      p2_reg,
    output logic [XB_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    output logic [HI_W-1:0]      a_hi,
    output logic                 ale,
    output logic                 code_rd_n,
    output logic                 rd_n,
    output logic                 wr_n
);
    localparam int ALE1_LO = CLKS_PER_STATE / 2;
    localparam int ALE1_HI = CLKS_PER_STATE - 1;
    localparam int ALE2_LO = 3 * CLKS_PER_STATE + CLKS_PER_STATE / 2;
    localparam int ALE2_HI = 4 * CLKS_PER_STATE - 1;
    localparam int ADDR_END = 3 * CLKS_PER_STATE - 1;
    localparam int STRB_LO = 3 * CLKS_PER_STATE;
    localparam int LAST = PHASES - 1;

    int   ph;
    logic is_fetch, is_read, is_write, is_data, in_strb;

    // Classify the current access and the position inside the cycle.
    always_comb begin
        ph       = int'(phase);
        is_fetch = busy && (cur.kind == XK_FETCH);
        is_read  = busy && (cur.kind == XK_DREAD);
        is_write = busy && (cur.kind == XK_DWRITE);
        is_data  = busy && (cur.kind != XK_FETCH);
        in_strb  = (ph >= STRB_LO);
    end

    // Drive the latch strobe and the three active-low strobes.
    always_comb begin
        ale = rst_n && (((ph >= ALE1_LO) && (ph <= ALE1_HI)) ||
                        ((ph >= ALE2_LO) && (ph <= ALE2_HI) && !is_data));
        code_rd_n = !(rst_n && is_fetch && in_strb);
        rd_n      = !(rst_n && is_read && in_strb);
        wr_n      = !(rst_n && is_write && in_strb && (ph < LAST));
    end

    // Multiplex address and data onto the ports.
    always_comb begin
        ad_oe  = rst_n && busy && ((ph <= ADDR_END) || is_write);
        ad_out = (ph <= ADDR_END) ? cur.addr[XB_DATA_W-1:0] : cur.wdata;
        a_hi   = (is_fetch || (is_data && cur.wide)) ?
                 cur.addr[XB_ADDR_W-1:XB_DATA_W] : p2_reg;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({code_rd_n, rd_n, wr_n}) >= 2);  // R6
    AST_ALE_NOT_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && (!rd_n || !wr_n)));  // R2
    AST_WR_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> ad_oe);  // R7
endmodule

// File: rtl/xbus_sequencer.sv
// Top of the external bus sequencer. It ties together the reset filter, the
// phase counter, the request control and the pin decoder. Assumes that
// req_kind never carries the reserved value and that requests are held
// until done.
module xbus_sequencer
    import xbus_pkg::*;
#(
    parameter int CLKS_PER_STATE = 2,
    parameter int STATES = 6,
    parameter int RST_MCYCLES = 2,
    localparam int PHASES = CLKS_PER_STATE * STATES,
    localparam int PH_W = $clog2(PHASES),
    localparam int RST_CLKS = RST_MCYCLES * PHASES,
    localparam int HI_W = XB_ADDR_W - XB_DATA_W
) (
    input  logic                 clk,
    input  logic                 reset_in,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic                 req_wide,
    input  logic [XB_ADDR_W-1:0] req_addr,
    input  logic [XB_DATA_W-1:0] req_wdata,
    input  logic [HI_W-1:0]      p2_reg,
    input  logic [XB_DATA_W-1:0] ad_in,
    output logic [XB_DATA_W-1:0] ad_out,
    output logic                 ad_oe,
    output logic [HI_W-1:0]      a_hi,
    output logic                 ale,
    output logic                 code_rd_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 done,
    output logic [XB_DATA_W-1:0] rdata
);
    logic            core_rst_n;
    logic [PH_W-1:0] phase;
    logic            cycle_end;
    logic            busy;
    xbus_req_t       req_in;
    xbus_req_t       cur;

    // Pack the request ports into the shared record.
    always_comb begin
        req_in.kind  = xbus_kind_e'(req_kind);
        req_in.wide  = req_wide;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
    end

    xbus_rst_filter #(.HOLD_CLKS(RST_CLKS)) u_rst (
        .clk(clk), .raw_rst(reset_in), .core_rst_n(core_rst_n)
    );

    xbus_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk(clk), .rst_n(core_rst_n), .phase(phase), .cycle_end(cycle_end)
    );

    xbus_access_ctl u_ctl (
        .clk(clk), .rst_n(core_rst_n), .cycle_end(cycle_end),
        .req_valid(req_valid), .req_in(req_in), .ad_in(ad_in),
        .busy(busy), .cur(cur), .done(done), .rdata(rdata)
    );

    xbus_pin_mux #(.CLKS_PER_STATE(CLKS_PER_STATE), .STATES(STATES)) u_pins (
        .clk(clk), .rst_n(core_rst_n), .phase(phase), .busy(busy), .cur(cur),
        .p2_reg(p2_reg), .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi),
        .ale(ale), .code_rd_n(code_rd_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    AST_READ_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (!core_rst_n)
        ($rose(rd_n) || $rose(code_rd_n)) |-> $past(done));  // R8
endmodule

// File: tb/xbus_sequencer_tb.sv
module xbus_sequencer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        reset_in, req_valid, req_wide;
    logic [1:0]  req_kind;
    logic [15:0] req_addr;
    logic [7:0]  req_wdata, p2_reg, ad_in;
    logic [7:0]  ad_out, a_hi, rdata;
    logic        ad_oe, ale, code_rd_n, rd_n, wr_n, done;

    int   ph;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 1'b0;
    logic [7:0] cur_rdin = 8'h00;
    logic [7:0] exp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_sequencer u_dut (
        .clk(clk), .reset_in(reset_in), .req_valid(req_valid),
        .req_kind(req_kind), .req_wide(req_wide), .req_addr(req_addr),
        .req_wdata(req_wdata), .p2_reg(p2_reg), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale),
        .code_rd_n(code_rd_n), .rd_n(rd_n), .wr_n(wr_n), .done(done),
        .rdata(rdata)
    );

    // {kind, wide, addr, wdata, p2, read byte}
    localparam logic [42:0] VECS [8] = '{
        {2'd0, 1'b1, 16'h1234, 8'h00, 8'h5A, 8'hA7},
        {2'd1, 1'b1, 16'hABCD, 8'h00, 8'h11, 8'h5A},
        {2'd1, 1'b0, 16'h0042, 8'h00, 8'h77, 8'hC4},
        {2'd2, 1'b1, 16'hFF00, 8'hC3, 8'h22, 8'h99},
        {2'd2, 1'b0, 16'h00FF, 8'h3C, 8'h81, 8'h66},
        {2'd0, 1'b0, 16'hFFFF, 8'h00, 8'h0F, 8'h01},
        {2'd1, 1'b1, 16'h0000, 8'h00, 8'hF0, 8'hFF},
        {2'd0, 1'b1, 16'h8001, 8'h00, 8'h33, 8'h80}
    };

    // Expected {ale, code_rd_n, rd_n, wr_n, ad_oe, port, a_hi, done}.
    function automatic logic [21:0] expect_bus(int p, bit act, logic [1:0] k,
            logic w, logic [15:0] a, logic [7:0] wd, logic [7:0] p2);
        logic e_ale, e_code, e_rd, e_wr, e_oe, e_done;
        logic [7:0] e_ad, e_hi;
        e_ale  = (p == 1) || (p == 7 && !(act && k != 2'd0));
        e_code = !(act && k == 2'd0 && p >= 6);
        e_rd   = !(act && k == 2'd1 && p >= 6);
        e_wr   = !(act && k == 2'd2 && p >= 6 && p <= 10);
        e_oe   = act && (p <= 5 || k == 2'd2);
        e_ad   = !e_oe ? 8'h00 : (p <= 5 ? a[7:0] : wd);
        e_hi   = (act && (k == 2'd0 || w)) ? a[15:8] : p2;
        e_done = act && p == 11;
        return {e_ale, e_code, e_rd, e_wr, e_oe, e_ad, e_hi, e_done};
    endfunction

    function automatic logic [21:0] got_bus();
        return {ale, code_rd_n, rd_n, wr_n, ad_oe, (ad_oe ? ad_out : 8'h00),
                a_hi, done};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at phase %0d: actual %h expected %h", tag, ph, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        ph = (ph == 11) ? 0 : ph + 1;
        ad_in = (ph == 11) ? cur_rdin : ~cur_rdin;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        reset_in = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_wide = 1'b0;
        req_addr = 16'h0; req_wdata = 8'h0; p2_reg = 8'h5A; ad_in = 8'h0;
        ph = 0;
        repeat (30) @(negedge clk);
        check("R11 in reset", 32'(got_bus()),
              32'(expect_bus(0, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));
        reset_in = 1'b0;
        @(negedge clk);
        ph = 0; ad_in = ~cur_rdin;
        exp_rdata = 8'h00;
        check("R11 rdata after reset", 32'(rdata), 32'(exp_rdata));

        // Vector walk: an idle cycle, then the access cycle.
        for (int i = 0; i < 8; i++) begin
            logic [1:0] k; logic w; logic [15:0] a; logic [7:0] wd, p2, rd;
            string tag;
            {k, w, a, wd, p2, rd} = VECS[i];
            tag = (k == 2'd0) ? "R1 R2 R4 R9 R10 fetch" :
                  (k == 2'd1) ? "R1 R2 R4 R5 R6 R10 read" :
                                "R1 R2 R4 R5 R7 R10 write";
            for (int p = 0; p < 12; p++) begin
                check("R3 R5 idle", 32'(got_bus()),
                      32'(expect_bus(ph, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));
                if (ph == 5) begin
                    req_valid = 1'b1; req_kind = k; req_wide = w;
                    req_addr = a; req_wdata = wd; p2_reg = p2; cur_rdin = rd;
                end
                step();
            end
            for (int p = 0; p < 12; p++) begin
                if (ph == 0) begin
                    req_addr = ~a; req_wdata = ~wd; req_wide = ~w;
                    req_kind = (k == 2'd2) ? 2'd0 : 2'd2;
                end
                check(tag, 32'(got_bus()),
                      32'(expect_bus(ph, 1, k, w, a, wd, p2_reg)));
                step();
            end
            if (k != 2'd2) exp_rdata = rd;
            check("R8 captured byte", 32'(rdata), 32'(exp_rdata));
        end
        req_valid = 1'b0;

        // Short reset pulse: 23 high edges must not reset.
        reset_in = 1'b1;
        repeat (23) begin
            step();
            check("R11 short pulse ignored", 32'(got_bus()),
                  32'(expect_bus(ph, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));
        end
        reset_in = 1'b0;
        repeat (12) begin
            step();
            check("R3 R11 after short pulse", 32'(got_bus()),
                  32'(expect_bus(ph, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));
        end
        check("R11 rdata kept after short pulse", 32'(rdata), 32'(exp_rdata));

        // Full reset pulse: 24 high edges reset.
        reset_in = 1'b1;
        repeat (23) begin
            step();
            check("R11 before qualification", 32'(got_bus()),
                  32'(expect_bus(ph, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));
        end
        repeat (6) begin
            step();
            check("R11 held reset", 32'(got_bus()),
                  32'(expect_bus(0, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));
        end
        check("R11 rdata cleared", 32'(rdata), 32'h0);
        reset_in = 1'b0;
        @(negedge clk);
        ph = 0;
        check("R11 restart phase 0", 32'(got_bus()),
              32'(expect_bus(0, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));
        step();
        check("R11 restart first strobe", 32'(got_bus()),
              32'(expect_bus(1, 0, 2'd0, 1'b0, 16'h0, 8'h0, p2_reg)));

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule